// File: doc/BRIEF.md
# Load Ordering Violation Detector

This block sits beside a circular load queue. Its job is to find loads that ran ahead of an older memory operation. An older store or load resolves its address through the trigger port. In that same cycle the block looks at the younger loads that already hold an address. The scan begins at the entry just after the trigger's queue slot, wraps around the queue, and ends before the tail the queue supplies. Two addresses conflict when they fall in the same coarse region, meaning they are equal once the low `REGION_SHIFT` bits are dropped. This test is conservative and does not depend on access size.

Only one violator is held at a time, and it is always the oldest one seen so far. A newly found conflicting load replaces it only if nothing is held or if the new load's sequence number is lower. When a violator is recorded, the block raises a one-cycle fault, counts the event and shows the violator's slot and sequence number.

Loads write their own address and sequence number into the shadow copy when they trigger. A load trigger scans only when the load path is not blocked. Allocating a slot clears its address-valid flag. A squash whose sequence number is older than the held violator's discards that violator.

Top module: `ord_viol_det`

## Requirements
- R1: After reset no violator is held, `fault_o` is 0, `viol_cnt_o` is 0 and every slot's address-valid flag is clear, so even a scan over the whole queue finds nothing.
- R2: A scan covers the slots `trig_idx_i+1`, `trig_idx_i+2`, and so on, modulo `DEPTH`, stopping before `tail_i`. When `tail_i` equals `trig_idx_i`, every other slot is scanned. Slots outside this range never match.
- R3: A slot takes part only while its address-valid flag is set. The flag is cleared by `alloc_i` for slot `alloc_idx_i` and set by a load trigger for slot `trig_idx_i`. If both hit the same slot in one cycle, allocation wins.
- R4: A slot matches when its stored address shifted right by `REGION_SHIFT` (default 8) equals the trigger address shifted the same way.
- R5: Only the first matching slot in scan order is considered. It becomes the violator if none is held or its sequence number is strictly lower than the held one. Otherwise the trigger produces no fault and the held violator is kept.
- R6: Each newly recorded violator drives `fault_o` high for exactly the cycle after the trigger and increments `viol_cnt_o` by one, wrapping at its width.
- R7: A load trigger (`trig_load_i`=1) with `ld_blocked_i`=1 records its address and sequence number but does not scan. A store trigger (`trig_load_i`=0) always scans and records nothing.
- R8: A squash with `squash_seq_i` strictly lower than the held violator's sequence number clears the violator in the next cycle. A squash with an equal or higher number keeps it. A squash applies before a trigger in the same cycle.
- R9: While `viol_vld_o` is 1, `viol_idx_o` and `viol_seq_o` give the slot and sequence number of the held violator, updated the cycle after it is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_i | input | 1 | Slot allocation, clears its address-valid flag |
| alloc_idx_i | input | IDX_W | Allocated slot |
| trig_i | input | 1 | An operation resolved its address |
| trig_load_i | input | 1 | 1 = load trigger, 0 = store trigger |
| ld_blocked_i | input | 1 | Load path blocked: load triggers do not scan |
| trig_idx_i | input | IDX_W | Load-queue slot of the trigger |
| trig_addr_i | input | ADDR_W | Trigger effective address |
| trig_seq_i | input | SEQ_W | Trigger sequence number |
| tail_i | input | IDX_W | Current load-queue tail |
| squash_i | input | 1 | Squash event |
| squash_seq_i | input | SEQ_W | Squash sequence number |
| fault_o | output | 1 | Violation fault pulse |
| viol_vld_o | output | 1 | A violator is held |
| viol_idx_o | output | IDX_W | Violator slot |
| viol_seq_o | output | SEQ_W | Violator sequence number |
| viol_cnt_o | output | CNT_W | Recorded-violation count |

## Verification
Directed cases start with a full-queue scan right after reset. They then show the following:
- A blocked load records its address without faulting, and a store later finds it.
- An equal or younger match blocks a later, older match that lies deeper in the scan. This separates a first-match scan from a best-match scan.
- A different region does not match, even when the low bits are close.
- A squash equal to the violator's number keeps it, and a lower one clears it.
- A wrapped scan finds slot 0 but never a slot at or past the tail.
- Allocation hides an entry that would otherwise match.

Random cycles then mix allocations, load and store triggers, blocking, moving tails and squashes over four crowded regions. A bench model predicts the fault, the violator fields and the count every cycle, so ordering and precedence errors show up as mismatches.

// File: rtl/ovd_pkg.sv
package ovd_pkg;
  typedef enum logic {
    TRIG_STORE = 1'b0,
    TRIG_LOAD  = 1'b1
  } trig_kind_e;

  function automatic int unsigned idx_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/ovd_lq_shadow.sv
module ovd_lq_shadow #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned RGN_W = 24,
  parameter int unsigned SEQ_W = 16,
  localparam int unsigned IDX_W = ovd_pkg::idx_bits(DEPTH)
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             alloc_i,
  input  logic [IDX_W-1:0]                 alloc_idx_i,
  input  logic                             rec_i,
  input  logic [IDX_W-1:0]                 rec_idx_i,
  input  logic [RGN_W-1:0]                 rec_rgn_i,
  input  logic [SEQ_W-1:0]                 rec_seq_i,
  output logic [DEPTH-1:0]                 valid_o,
  output logic [DEPTH-1:0][RGN_W-1:0]      rgn_o,
  output logic [DEPTH-1:0][SEQ_W-1:0]      seq_o
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic hit_alloc, hit_rec;
    assign hit_alloc = alloc_i && (alloc_idx_i == IDX_W'(e));
    assign hit_rec   = rec_i && (rec_idx_i == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[e] <= 1'b0;
        rgn_o[e]   <= '0;
        seq_o[e]   <= '0;
      end else if (hit_alloc) begin
        valid_o[e] <= 1'b0;
      end else if (hit_rec) begin
        valid_o[e] <= 1'b1;
        rgn_o[e]   <= rec_rgn_i;
        seq_o[e]   <= rec_seq_i;
      end
    end
  end

  AST_REC_SETS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_i && !(alloc_i && alloc_idx_i == rec_idx_i)) |=> valid_o[$past(rec_idx_i)]); // R3
  AST_ALLOC_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |=> !valid_o[$past(alloc_idx_i)]); // R3
endmodule

// File: rtl/ovd_scan.sv
module ovd_scan #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned RGN_W = 24,
  localparam int unsigned IDX_W = ovd_pkg::idx_bits(DEPTH),
  localparam int unsigned CW    = IDX_W + 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [DEPTH-1:0]            valid_i,
  input  logic [DEPTH-1:0][RGN_W-1:0] rgn_i,
  input  logic [IDX_W-1:0]            trig_idx_i,
  input  logic [RGN_W-1:0]            trig_rgn_i,
  input  logic [IDX_W-1:0]            tail_i,
  output logic                        hit_o,
  output logic [IDX_W-1:0]            hit_idx_o
);
  logic [CW-1:0]                  span;
  logic [DEPTH-1:0][IDX_W-1:0]    ent;
  logic [DEPTH-1:0]               cand;

  // Number of slots from trigger to tail; equal pointers mean a full ring.
  always_comb begin
    if (tail_i >= trig_idx_i) span = CW'(tail_i) - CW'(trig_idx_i);
    else                      span = CW'(tail_i) + CW'(DEPTH) - CW'(trig_idx_i);
    if (span == '0) span = CW'(DEPTH);
  end

  assign ent[0]  = trig_idx_i;
  assign cand[0] = 1'b0;

  for (genvar k = 1; k < DEPTH; k++) begin : g_off
    logic [CW-1:0] sum;
    assign sum     = CW'(trig_idx_i) + CW'(k);
    assign ent[k]  = (sum >= CW'(DEPTH)) ? IDX_W'(sum - CW'(DEPTH)) : IDX_W'(sum);
    assign cand[k] = (CW'(k) < span) && valid_i[ent[k]] && (rgn_i[ent[k]] == trig_rgn_i);
  end

  // Lowest offset wins: first match in scan order.
  always_comb begin
    hit_o     = 1'b0;
    hit_idx_o = '0;
    for (int k = DEPTH - 1; k >= 1; k--) begin
      if (cand[k]) begin
        hit_o     = 1'b1;
        hit_idx_o = ent[k];
      end
    end
  end

  AST_HIT_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> valid_i[hit_idx_o]); // R3
  AST_HIT_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (rgn_i[hit_idx_o] == trig_rgn_i)); // R4
  AST_HIT_NOT_SELF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (hit_idx_o != trig_idx_i)); // R2
  AST_HIT_NOT_TAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && tail_i != trig_idx_i) |-> (hit_idx_o != tail_i)); // R2
endmodule

// File: rtl/ovd_viol_track.sv
module ovd_viol_track #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned SEQ_W = 16,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned IDX_W = ovd_pkg::idx_bits(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scan_en_i,
  input  logic              hit_i,
  input  logic [IDX_W-1:0]  hit_idx_i,
  input  logic [SEQ_W-1:0]  hit_seq_i,
  input  logic              squash_i,
  input  logic [SEQ_W-1:0]  squash_seq_i,
  output logic              fault_o,
  output logic              viol_vld_o,
  output logic [IDX_W-1:0]  viol_idx_o,
  output logic [SEQ_W-1:0]  viol_seq_o,
  output logic [CNT_W-1:0]  viol_cnt_o
);
  logic keep, take;

  // Squash is resolved before the trigger compares against the held violator.
  assign keep = viol_vld_o && !(squash_i && (squash_seq_i < viol_seq_o));
  assign take = scan_en_i && hit_i && (!keep || (hit_seq_i < viol_seq_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_o    <= 1'b0;
      viol_vld_o <= 1'b0;
      viol_idx_o <= '0;
      viol_seq_o <= '0;
      viol_cnt_o <= '0;
    end else begin
      fault_o <= take;
      if (take) begin
        viol_vld_o <= 1'b1;
        viol_idx_o <= hit_idx_i;
        viol_seq_o <= hit_seq_i;
        viol_cnt_o <= viol_cnt_o + CNT_W'(1);
      end else if (!keep) begin
        viol_vld_o <= 1'b0;
      end
    end
  end

  AST_FAULT_HAS_VIOL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> viol_vld_o); // R9
  AST_FAULT_COUNTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (viol_cnt_o == $past(viol_cnt_o) + CNT_W'(1))); // R6
  AST_CNT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> (viol_cnt_o == $past(viol_cnt_o))); // R6
  AST_OLDER_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_vld_o && !squash_i) |=> (!fault_o || (viol_seq_o < $past(viol_seq_o)))); // R5
  AST_SQUASH_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_vld_o && squash_i && (squash_seq_i < viol_seq_o) && !scan_en_i) |=> !viol_vld_o); // R8
  AST_NO_SCAN_NO_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_en_i |=> !fault_o); // R7
endmodule

// File: rtl/ord_viol_det.sv
module ord_viol_det #(
  parameter int unsigned DEPTH        = 16,
  parameter int unsigned ADDR_W       = 32,
  parameter int unsigned SEQ_W        = 16,
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned REGION_SHIFT = 8,
  localparam int unsigned IDX_W = ovd_pkg::idx_bits(DEPTH),
  localparam int unsigned RGN_W = ADDR_W - REGION_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [IDX_W-1:0]  alloc_idx_i,
  input  logic              trig_i,
  input  logic              trig_load_i,
  input  logic              ld_blocked_i,
  input  logic [IDX_W-1:0]  trig_idx_i,
  input  logic [ADDR_W-1:0] trig_addr_i,
  input  logic [SEQ_W-1:0]  trig_seq_i,
  input  logic [IDX_W-1:0]  tail_i,
  input  logic              squash_i,
  input  logic [SEQ_W-1:0]  squash_seq_i,
  output logic              fault_o,
  output logic              viol_vld_o,
  output logic [IDX_W-1:0]  viol_idx_o,
  output logic [SEQ_W-1:0]  viol_seq_o,
  output logic [CNT_W-1:0]  viol_cnt_o
);
  import ovd_pkg::*;

  trig_kind_e                   kind;
  logic [RGN_W-1:0]             trig_rgn;
  logic                         rec, scan_en, hit;
  logic [IDX_W-1:0]             hit_idx;
  logic [DEPTH-1:0]             ent_vld;
  logic [DEPTH-1:0][RGN_W-1:0]  ent_rgn;
  logic [DEPTH-1:0][SEQ_W-1:0]  ent_seq;

  assign kind     = trig_kind_e'(trig_load_i);
  assign trig_rgn = RGN_W'(trig_addr_i >> REGION_SHIFT);
  assign rec      = trig_i && (kind == TRIG_LOAD);
  assign scan_en  = trig_i && !((kind == TRIG_LOAD) && ld_blocked_i);

  ovd_lq_shadow #(.DEPTH(DEPTH), .RGN_W(RGN_W), .SEQ_W(SEQ_W)) u_shadow (
    .clk_i, .rst_ni,
    .alloc_i, .alloc_idx_i,
    .rec_i     (rec),
    .rec_idx_i (trig_idx_i),
    .rec_rgn_i (trig_rgn),
    .rec_seq_i (trig_seq_i),
    .valid_o   (ent_vld),
    .rgn_o     (ent_rgn),
    .seq_o     (ent_seq)
  );

  ovd_scan #(.DEPTH(DEPTH), .RGN_W(RGN_W)) u_scan (
    .clk_i, .rst_ni,
    .valid_i    (ent_vld),
    .rgn_i      (ent_rgn),
    .trig_idx_i,
    .trig_rgn_i (trig_rgn),
    .tail_i,
    .hit_o      (hit),
    .hit_idx_o  (hit_idx)
  );

  ovd_viol_track #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_track (
    .clk_i, .rst_ni,
    .scan_en_i    (scan_en),
    .hit_i        (hit),
    .hit_idx_i    (hit_idx),
    .hit_seq_i    (ent_seq[hit_idx]),
    .squash_i, .squash_seq_i,
    .fault_o, .viol_vld_o, .viol_idx_o, .viol_seq_o, .viol_cnt_o
  );

  AST_BLOCKED_LOAD_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && trig_load_i && ld_blocked_i) |=> !fault_o); // R7
endmodule

// File: tb/ord_viol_det_test.sv
module ord_viol_det_test;
  localparam int D = 16;
  localparam int AW = 32;
  localparam int SW = 16;
  localparam int CW = 16;
  localparam int SH = 8;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          alloc, trig, tld, blk, sq;
  logic [IW-1:0] aidx, tidx, tail;
  logic [AW-1:0] taddr;
  logic [SW-1:0] tseq, sqseq;
  logic          fault, vvld;
  logic [IW-1:0] vidx;
  logic [SW-1:0] vseq;
  logic [CW-1:0] vcnt;

  ord_viol_det uut (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_i(alloc), .alloc_idx_i(aidx),
    .trig_i(trig), .trig_load_i(tld), .ld_blocked_i(blk),
    .trig_idx_i(tidx), .trig_addr_i(taddr), .trig_seq_i(tseq),
    .tail_i(tail), .squash_i(sq), .squash_seq_i(sqseq),
    .fault_o(fault), .viol_vld_o(vvld), .viol_idx_o(vidx),
    .viol_seq_o(vseq), .viol_cnt_o(vcnt)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // Bench model
  bit            m_v   [D];
  int unsigned   m_rgn [D];
  int unsigned   m_seq [D];
  bit            e_fault, e_vld;
  int unsigned   e_idx, e_seq, e_cnt;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit first_hit(input int idx, input int tl,
                                   input int unsigned rgn, output int hidx);
    hidx = 0;
    for (int n = 0; n < D - 1; n++) begin
      int e = (idx + 1 + n) % D;
      if (e == tl) return 1'b0;
      if (m_v[e] && m_rgn[e] == rgn) begin
        hidx = e;
        return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  function automatic void model_step();
    bit keep, take, h;
    int hi;
    int unsigned rgn = taddr >> SH;
    keep = e_vld && !(sq && sqseq < e_seq);
    h = 1'b0; hi = 0;
    if (trig && !(tld && blk)) h = first_hit(tidx, tail, rgn, hi);
    take = h && (!keep || m_seq[hi] < e_seq);
    e_fault = take;
    if (take) begin
      e_vld = 1'b1; e_idx = hi; e_seq = m_seq[hi];
      e_cnt = (e_cnt + 1) % (1 << CW);
    end else if (!keep) e_vld = 1'b0;
    for (int e = 0; e < D; e++) begin
      if (alloc && aidx == e) m_v[e] = 1'b0;
      else if (trig && tld && tidx == e) begin
        m_v[e] = 1'b1; m_rgn[e] = rgn; m_seq[e] = tseq;
      end
    end
  endfunction

  task automatic compare(input string req);
    check(fault == e_fault, req, "fault_o", fault, e_fault);
    check(vvld == e_vld, req, "viol_vld_o", vvld, e_vld);
    if (e_vld) begin
      check(vidx == e_idx, req, "viol_idx_o", vidx, e_idx);
      check(vseq == e_seq, req, "viol_seq_o", vseq, e_seq);
    end
    check(vcnt == e_cnt, "R6", "viol_cnt_o", vcnt, e_cnt);
  endtask

  task automatic idle();
    alloc = 0; aidx = 0; trig = 0; tld = 0; blk = 0; tidx = 0;
    taddr = 0; tseq = 0; sq = 0; sqseq = 0;
  endtask

  task automatic cyc(input string req);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare(req);
    idle();
  endtask

  task automatic do_trig(input bit ld, input bit bl, input int idx, input int tl,
                         input int unsigned addr, input int unsigned s, input string req);
    trig = 1; tld = ld; blk = bl; tidx = IW'(idx); tail = IW'(tl);
    taddr = addr; tseq = SW'(s);
    cyc(req);
  endtask

  initial begin
    for (int e = 0; e < D; e++) begin m_v[e] = 0; m_rgn[e] = 0; m_seq[e] = 0; end
    e_fault = 0; e_vld = 0; e_idx = 0; e_seq = 0; e_cnt = 0;
    idle(); tail = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state and empty full-ring scan
    check(!fault && !vvld && vcnt == 0, "R1", "reset outputs", {fault, vvld}, 0);
    do_trig(0, 0, 0, 0, 32'h1234, 1, "R1");
    // R7: blocked load records silently
    do_trig(1, 1, 3, 8, 32'h1234, 10, "R7");
    // R4/R2/R6/R9: store finds slot 3
    do_trig(0, 0, 1, 8, 32'h12ff, 0, "R4");
    check(vvld && vidx == 3 && vseq == 10, "R9", "violator id", vidx, 3);
    // R5: equal seq does not replace; deeper older match shadowed
    do_trig(1, 1, 5, 8, 32'h1250, 12, "R7");
    do_trig(1, 1, 6, 8, 32'h1260, 5, "R7");
    do_trig(0, 0, 1, 8, 32'h1200, 0, "R5");
    do_trig(0, 0, 4, 8, 32'h1200, 0, "R5");
    check(!fault && vseq == 10, "R5", "first match only", vseq, 10);
    // R4: other region
    do_trig(0, 0, 1, 8, 32'h1300, 0, "R4");
    // R7: unblocked load scans (finds slot 5, seq 12 not older): no fault
    do_trig(1, 0, 4, 8, 32'h1201, 3, "R7");
    // R8: equal squash keeps, older squash clears
    sq = 1; sqseq = 10; cyc("R8");
    check(vvld, "R8", "kept on equal squash", vvld, 1);
    sq = 1; sqseq = 9; cyc("R8");
    check(!vvld, "R8", "cleared on older squash", vvld, 0);
    // R8: squash before trigger in the same cycle
    do_trig(0, 0, 4, 8, 32'h1200, 0, "R8");
    sq = 1; sqseq = 0; do_trig(0, 0, 4, 8, 32'h1200, 0, "R8");
    check(fault, "R8", "squash then retrigger", fault, 1);
    // R2: wrap past end; slot 3 lies at/after tail and is skipped
    sq = 1; sqseq = 0; cyc("R8");
    do_trig(1, 1, 0, 2, 32'h4400, 20, "R7");
    do_trig(1, 1, 3, 2, 32'h4400, 21, "R7");
    do_trig(0, 0, 12, 2, 32'h4480, 0, "R2");
    check(fault && vidx == 0, "R2", "wrap hit", vidx, 0);
    sq = 1; sqseq = 0; cyc("R8");
    do_trig(0, 0, 14, 3, 32'h4400, 0, "R2");
    check(fault && vidx == 0, "R2", "tail excluded", vidx, 0);
    // R3: allocation hides slot
    sq = 1; sqseq = 0; cyc("R8");
    alloc = 1; aidx = 0; cyc("R3");
    do_trig(0, 0, 12, 2, 32'h4400, 0, "R3");
    check(!fault, "R3", "allocated slot ignored", fault, 0);
    // R5: random mix
    for (int i = 0; i < 4000; i++) begin
      alloc = ($urandom % 4) == 0; aidx = IW'($urandom);
      trig  = ($urandom % 2) == 0; tld = $urandom % 2; blk = ($urandom % 4) == 0;
      tidx  = IW'($urandom); tail = IW'($urandom);
      taddr = (($urandom % 4) << SH) | ($urandom % 256);
      tseq  = SW'($urandom % 64);
      sq    = ($urandom % 10) == 0; sqseq = SW'($urandom % 64);
      cyc("R5");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule